// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block times the clock line of an I2C master. It drives SCL low for a programmed low phase, releases it, and then waits until the filtered SCL level reads high. Only then does it count the programmed high phase. A slave that holds SCL low after the release therefore stretches the period, and the master's high time is never cut short. The byte engine asks for clocking through `run` and gets a one-cycle strobe at the start of each low phase and each high phase.

A phase is measured in internal cycles. One internal cycle is 2^P reference cycles, where P is a 3-bit prescale code. Each phase lasts the programmed 5-bit count plus a fixed overhead. The overhead stands for the synchronizer and the noise filter: 4 internal cycles when P is 0 and 3 when P is nonzero. The raw SCL input passes through a two-flop synchronizer and a filter that needs two matching samples, so single-cycle glitches are dropped. The generator runs only while `en` is high and `srst` is low.

Top module: `scl_rate_gen`

## Requirements
- R1: After `rst`, SCL is released, both strobes are low, the low and high counts are 31 and the prescale code is 0.
- R2: While running, every low phase drives `scl_drive_low` high for (LO+OV)·2^P reference cycles, where OV is 4 when P=0 and 3 otherwise.
- R3: A high phase begins with a one-cycle `high_stb`. SCL stays released for (HI+OV)·2^P reference cycles counted from that strobe.
- R4: Raw SCL is synchronized and filtered. When SCL is released and nobody holds it, `high_stb` rises 5 reference cycles after `scl_drive_low` falls. A high pulse on `scl_in` that lasts one reference cycle starts no high phase.
- R5: While an external device holds SCL low, no high phase starts. `high_stb` comes 5 reference cycles after the line is let go.
- R6: A mode write loads the prescale code from bits 6:4 only if bit 3 of the same write is 1. Otherwise the code is unchanged.
- R7: A period write takes the count from bits 4:0 and ignores bits 7:5. A written count of 0 is stored as 1.
- R8: The low count and the high count are sampled when their phase starts. A write during a phase first affects the next phase of that kind.
- R9: When `en` is low or `srst` is high at a clock edge, SCL is released and no strobe follows until the generator is enabled again.
- R10: At the end of a high phase, `run` high starts a new low phase. `run` low leaves SCL released and idle.
- R11: `low_stb` pulses for exactly one cycle at the first cycle of each low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| srst | input | 1 | Holds the generator idle while high; registers keep their values |
| run | input | 1 | Byte engine requests clocking |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 8 | Mode write data: bits 6:4 prescale code, bit 3 unlock |
| lo_wr | input | 1 | Low-count write strobe |
| hi_wr | input | 1 | High-count write strobe |
| per_wdata | input | 8 | Period write data, count in bits 4:0 |
| scl_in | input | 1 | Raw SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low |
| low_stb | output | 1 | One-cycle strobe at the start of a low phase |
| high_stb | output | 1 | One-cycle strobe at the start of a high phase |

## Verification
The generator is run over an open-drain line model with several count and prescale settings: default counts, small counts at prescale 0 and at prescale 2, a count of 0, and a write whose unlock bit is clear. Together these separate the two overhead values, the shift by the prescale code and the clamp of zero counts. Stretch and glitch patterns hold the line low past the release and inject a one-cycle high pulse. They show that the high count follows the filtered line and not the generator's own release. Writes in the middle of a phase, toggles of `srst`/`en`, and dropping `run` during a high phase check when settings are sampled and when the generator stops. A behavioural model is compared with the outputs on every clock.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LOW     = 2'd1,
    PH_WAIT_HI = 2'd2,
    PH_HIGH    = 2'd3
  } phase_e;
endpackage

// File: rtl/scl_gen_cfg.sv
module scl_gen_cfg #(
  parameter int BR_W  = 5,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [7:0]       mode_wdata,
  input  logic             lo_wr,
  input  logic             hi_wr,
  input  logic [7:0]       per_wdata,
  output logic [BR_W-1:0]  lo_q,
  output logic [BR_W-1:0]  hi_q,
  output logic [PRE_W-1:0] pre_q
);
  localparam int UNLOCK_BIT = 3;
  localparam int PRE_LSB    = 4;

  logic [BR_W-1:0] cnt_in;
  logic [BR_W-1:0] cnt_fix;
  logic            unused_bits;

  assign cnt_in      = per_wdata[BR_W-1:0];
  assign cnt_fix     = (cnt_in == '0) ? BR_W'(1) : cnt_in;
  assign unused_bits = ^{mode_wdata[7], mode_wdata[2:0], per_wdata[7:BR_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '1;
      hi_q  <= '1;
      pre_q <= '0;
    end else begin
      if (lo_wr) lo_q <= cnt_fix;
      if (hi_wr) hi_q <= cnt_fix;
      if (mode_wr && mode_wdata[UNLOCK_BIT]) pre_q <= mode_wdata[PRE_LSB +: PRE_W];
    end
  end

  // R7
  lo_nonzero_chk: assert property (@(posedge clk) disable iff (rst) (lo_q != '0) && (hi_q != '0));
  // R6
  pre_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && !mode_wdata[UNLOCK_BIT]) |=> $stable(pre_q));
endmodule

// File: rtl/scl_in_filter.sv
module scl_in_filter (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      s3    <= 1'b1;
      level <= 1'b1;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
      if (s2 == s3) level <= s2;
    end
  end

  // R4
  filt_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> ($past(raw, 3) && $past(raw, 4)));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int BR_W  = 5,
  parameter int PRE_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       srst,
  input  logic       run,
  input  logic       mode_wr,
  input  logic [7:0] mode_wdata,
  input  logic       lo_wr,
  input  logic       hi_wr,
  input  logic [7:0] per_wdata,
  input  logic       scl_in,
  output logic       scl_drive_low,
  output logic       low_stb,
  output logic       high_stb
);
  import scl_gen_pkg::*;

  localparam int CNT_W = BR_W + 1 + (2 ** PRE_W) - 1;

  logic [BR_W-1:0]  lo_q, hi_q;
  logic [PRE_W-1:0] pre_q;
  logic             scl_seen;
  logic             active;
  logic [CNT_W-1:0] len_lo, len_hi, cnt;
  phase_e           ph;

  scl_gen_cfg #(.BR_W(BR_W), .PRE_W(PRE_W)) u_cfg (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .lo_wr(lo_wr), .hi_wr(hi_wr), .per_wdata(per_wdata),
    .lo_q(lo_q), .hi_q(hi_q), .pre_q(pre_q)
  );

  scl_in_filter u_filt (.clk(clk), .rst(rst), .raw(scl_in), .level(scl_seen));

  function automatic logic [CNT_W-1:0] phase_len(input logic [BR_W-1:0] br,
                                                 input logic [PRE_W-1:0] p);
    logic [CNT_W-1:0] base;
    base = CNT_W'(br) + ((p == '0) ? CNT_W'(4) : CNT_W'(3));
    return base << p;
  endfunction

  assign active = en && !srst;
  assign len_lo = phase_len(lo_q, pre_q);
  assign len_hi = phase_len(hi_q, pre_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph            <= PH_IDLE;
      cnt           <= '0;
      scl_drive_low <= 1'b0;
      low_stb       <= 1'b0;
      high_stb      <= 1'b0;
    end else begin
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      if (!active) begin
        ph            <= PH_IDLE;
        scl_drive_low <= 1'b0;
      end else begin
        unique case (ph)
          PH_IDLE: if (run) begin
            ph            <= PH_LOW;
            cnt           <= len_lo - 1'b1;
            scl_drive_low <= 1'b1;
            low_stb       <= 1'b1;
          end
          PH_LOW: if (cnt == '0) begin
            ph            <= PH_WAIT_HI;
            scl_drive_low <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
          PH_WAIT_HI: if (scl_seen) begin
            ph       <= PH_HIGH;
            cnt      <= len_hi - 1'b1;
            high_stb <= 1'b1;
          end
          PH_HIGH: if (cnt == '0) begin
            if (run) begin
              ph            <= PH_LOW;
              cnt           <= len_lo - 1'b1;
              scl_drive_low <= 1'b1;
              low_stb       <= 1'b1;
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  // R9
  no_drive_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!scl_drive_low && !low_stb && !high_stb));
  // R3
  high_start_released_chk: assert property (@(posedge clk) disable iff (rst)
    high_stb |-> !scl_drive_low);
  // R11
  low_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    low_stb |=> !low_stb);
  // R10
  low_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> low_stb);
endmodule

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;
  localparam time CYC = 10ns;

  logic clk = 1'b0;
  logic rst, en, srst, run, mode_wr, lo_wr, hi_wr, hold, glitch;
  logic [7:0] mode_wdata, per_wdata;
  logic scl_line, scl_drive_low, low_stb, high_stb;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CYC/2) clk = ~clk;

  assign scl_line = glitch ? 1'b1 : ~(scl_drive_low | hold);

  scl_rate_gen u_dut (
    .clk(clk), .rst(rst), .en(en), .srst(srst), .run(run),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .per_wdata(per_wdata), .scl_in(scl_line),
    .scl_drive_low(scl_drive_low), .low_stb(low_stb), .high_stb(high_stb)
  );

  // behavioural reference model
  int m_lo, m_hi, m_pre, m_phase, m_left;
  int samp[4];
  bit m_filt, m_drv, m_ls, m_hs;

  function automatic int plen(input int br, input int p);
    int b = (br == 0) ? 1 : br;
    return (b + ((p == 0) ? 4 : 3)) * (1 << p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lo = 31; m_hi = 31; m_pre = 0; m_phase = 0; m_left = 0;
      foreach (samp[i]) samp[i] = 1;
      m_filt = 1; m_drv = 0; m_ls = 0; m_hs = 0;
    end else begin
      bit pf;
      pf = m_filt;
      samp[3] = samp[2]; samp[2] = samp[1]; samp[1] = samp[0]; samp[0] = scl_line;
      if (samp[2] == samp[3]) m_filt = samp[2][0];
      m_ls = 0; m_hs = 0;
      if (!en || srst) begin
        m_phase = 0; m_drv = 0;
      end else if (m_phase == 0) begin
        if (run) begin m_phase = 1; m_left = plen(m_lo, m_pre) - 1; m_drv = 1; m_ls = 1; end
      end else if (m_phase == 1) begin
        if (m_left == 0) begin m_phase = 2; m_drv = 0; end else m_left--;
      end else if (m_phase == 2) begin
        if (pf) begin m_phase = 3; m_left = plen(m_hi, m_pre) - 1; m_hs = 1; end
      end else begin
        if (m_left == 0) begin
          if (run) begin m_phase = 1; m_left = plen(m_lo, m_pre) - 1; m_drv = 1; m_ls = 1; end
          else m_phase = 0;
        end else m_left--;
      end
      if (mode_wr && mode_wdata[3]) m_pre = int'(mode_wdata[6:4]);
      if (lo_wr) m_lo = int'(per_wdata[4:0]);
      if (hi_wr) m_hi = int'(per_wdata[4:0]);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (scl_drive_low !== m_drv || low_stb !== m_ls || high_stb !== m_hs) begin
        n_bad++;
        $display("FAIL %s model: act drv/ls/hs=%b%b%b exp=%b%b%b at %0t", cur_req,
                 scl_drive_low, low_stb, high_stb, m_drv, m_ls, m_hs, $time);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr_mode(input logic [7:0] d);
    @(negedge clk); mode_wr = 1; mode_wdata = d;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic wr_per(input bit hi, input logic [7:0] d);
    @(negedge clk); per_wdata = d; if (hi) hi_wr = 1; else lo_wr = 1;
    @(negedge clk); lo_wr = 0; hi_wr = 0;
  endtask

  task automatic wait_lstb();
    int k = 0;
    do begin @(negedge clk); k++; end while (!low_stb && k < 20000);
  endtask

  task automatic meas_low(output int n);
    wait_lstb();
    n = 0;
    while (scl_drive_low && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic meas_high(output int n);
    int k = 0;
    do begin @(negedge clk); k++; end while (!high_stb && k < 20000);
    n = 0;
    while (!scl_drive_low && n < 20000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CYC * 150000);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    finish_run();
  end

  initial begin
    int n;
    int cnt_ls;
    rst = 1; en = 0; srst = 0; run = 0; mode_wr = 0; lo_wr = 0; hi_wr = 0;
    hold = 0; glitch = 0; mode_wdata = 0; per_wdata = 0;
    repeat (4) @(negedge clk);
    rst = 0; en = 1;
    repeat (6) @(negedge clk);
    cur_req = "R1";
    check(!scl_drive_low && !low_stb && !high_stb, "R1 idle after reset", scl_drive_low, 0);

    // R1 / R2 defaults: (31+4)
    run = 1;
    meas_low(n);  check(n == 35, "R1 default low", n, 35);
    meas_high(n); check(n == 35, "R3 default high", n, 35);

    // R2 / R3 small counts, prescale 0
    cur_req = "R2";
    wr_per(0, 8'd3); wr_per(1, 8'd5);
    meas_low(n);  meas_low(n);  check(n == 7, "R2 low P=0", n, 7);
    cur_req = "R3";
    meas_high(n); check(n == 9, "R3 high P=0", n, 9);

    // R6 prescale with unlock
    cur_req = "R6";
    wr_mode(8'h28);
    meas_low(n); meas_low(n); check(n == 24, "R6/R2 low P=2", n, 24);
    meas_high(n); check(n == 32, "R6/R3 high P=2", n, 32);
    wr_mode(8'h50);
    meas_low(n); meas_low(n); check(n == 24, "R6 locked write ignored", n, 24);

    // R7 zero and reserved bits
    cur_req = "R7";
    wr_mode(8'h08);
    wr_per(0, 8'hE0);
    meas_low(n); meas_low(n); check(n == 5, "R7 zero count as 1", n, 5);
    wr_per(0, 8'hE2);
    meas_low(n); meas_low(n); check(n == 6, "R7 upper bits ignored", n, 6);

    // R4 unobstructed release to high strobe
    cur_req = "R4";
    wr_per(0, 8'd3);
    meas_low(n); meas_low(n);
    n = 0;
    do begin n++; @(negedge clk); end while (!high_stb && n < 100);
    check(n == 5, "R4 release to high_stb", n, 5);

    // R5 stretching and R4 glitch rejection
    cur_req = "R5";
    wait_lstb(); hold = 1;
    while (scl_drive_low) @(negedge clk);
    cnt_ls = 0;
    repeat (10) begin @(negedge clk); if (high_stb) cnt_ls++; end
    check(cnt_ls == 0, "R5 no high while held", cnt_ls, 0);
    cur_req = "R4";
    glitch = 1; @(negedge clk); glitch = 0;
    cnt_ls = 0;
    repeat (10) begin @(negedge clk); if (high_stb) cnt_ls++; end
    check(cnt_ls == 0, "R4 glitch ignored", cnt_ls, 0);
    cur_req = "R5";
    hold = 0; n = 0;
    do begin @(negedge clk); n++; end while (!high_stb && n < 100);
    check(n == 5, "R5 high after stretch release", n, 5);

    // R8 mid-phase writes
    cur_req = "R8";
    wait_lstb();
    lo_wr = 1; per_wdata = 8'd8; n = 1;
    @(negedge clk); lo_wr = 0;
    while (scl_drive_low) begin n++; @(negedge clk); end
    check(n == 7, "R8 current low unchanged", n, 7);
    meas_low(n); check(n == 12, "R8 next low uses new", n, 12);

    // R11 strobe width
    cur_req = "R11";
    wait_lstb(); @(negedge clk);
    check(!low_stb, "R11 low_stb one cycle", low_stb, 0);

    // R9 soft reset and disable
    cur_req = "R9";
    wait_lstb(); @(negedge clk); srst = 1; @(negedge clk);
    check(!scl_drive_low, "R9 srst releases", scl_drive_low, 0);
    cnt_ls = 0;
    repeat (30) begin @(negedge clk); if (low_stb || high_stb) cnt_ls++; end
    check(cnt_ls == 0, "R9 no strobes in srst", cnt_ls, 0);
    srst = 0;
    wait_lstb(); @(negedge clk); en = 0; @(negedge clk);
    check(!scl_drive_low, "R9 en low releases", scl_drive_low, 0);
    en = 1;

    // R10 run dropped in high phase
    cur_req = "R10";
    meas_low(n);
    do @(negedge clk); while (!high_stb);
    run = 0;
    cnt_ls = 0;
    repeat (60) begin @(negedge clk); if (low_stb || scl_drive_low) cnt_ls++; end
    check(cnt_ls == 0, "R10 idle after run low", cnt_ls, 0);
    run = 1;
    meas_low(n); check(n == 12, "R10 restart low", n, 12);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule